// File: doc/BRIEF.md
# Multiple-Cycle Programmable Byte ROM

This block is a synthesizable behavioural model of a byte-wide ROM that can be erased and reprogrammed electrically. It is meant to stand in for such a memory in a chip-level or board-level simulation. Every input is sampled on a free-running clock. The active-low select, output-enable and write-enable pins, plus two flags that say a high voltage is present on the output-enable pin and on address bit 9, choose one of seven modes: standby, output disable, read, identification, write inhibit, byte program and chip erase. The model drives an 8-bit data output and a separate enable for the tri-state buffer. A testbench or a wrapper can turn these into a bidirectional bus.

Writes need the write-enable pin to stay low for a minimum number of clock cycles. Program and erase each have their own cycle-count parameter. Programming can only clear bits: the stored byte becomes the old byte ANDed with the new data. Erase fills the whole array with FFh. A pulse that is too short, or one that is broken off by a mode change, leaves the array untouched and raises an error flag. The depth comes from an address-width parameter. The default is 10 bits, so that the array stays small when the block is elaborated with defaults. Bit 9 of the address is still an ordinary address bit in read mode.

Top module: `prom_model`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `we_n`=1 and both high-voltage flags low, `dout_oe` is 1 and `dout` shows the stored byte at `addr` in the same cycle. Every address bit, bit 9 included, takes part in the lookup.
- R2: With `ce_n`=1, `dout_oe` is 0 whatever the other inputs are.
- R3: With `ce_n`=0 and `oe_hv`=0, `dout_oe` is 0 if `oe_n`=1 (output disable). It is also 0 if `oe_n`=0 and `we_n`=0 (write inhibit).
- R4: In program mode (`ce_n`=0, `oe_hv`=1, `a9_hv`=0), a falling edge of `we_n` captures `addr` and `din`. If `we_n` is then sampled low on at least PROG_CYCLES rising clock edges, the byte is written on the edge that first samples `we_n` high again.
- R5: A program writes old AND new. Bits only go from 1 to 0, and writing FFh leaves a byte unchanged.
- R6: In erase mode (`ce_n`=0, `oe_hv`=1, `a9_hv`=1), a `we_n` pulse of at least ERASE_CYCLES samples sets every location to FFh. The values of `addr` and `din` do not matter.
- R7: In identification mode (`ce_n`=0, `oe_n`=0, `we_n`=1, `oe_hv`=0, `a9_hv`=1), `dout_oe` is 1. `addr[1:0]` selects the output: 00 gives 9Dh, 01 gives 9Bh, 10 and 11 give 00h. All higher address bits are ignored.
- R8: A pulse shorter than its minimum leaves the array unchanged. `pulse_error` goes to 1 on the edge that ends the pulse and stays there until the next pulse starts.
- R9: `busy` is 1 from the edge that sees the falling edge of `we_n` until the operation commits or aborts. While `busy` is 1, `dout_oe` is 0.
- R10: After reset, every location reads FFh, and `busy` and `pulse_error` are 0.
- R11: If the mode leaves program or erase during a pulse (for example, `ce_n` goes high), the pulse is aborted. The array is unchanged and `pulse_error` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; array fills with FFh |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable at normal level |
| we_n | input | 1 | Active-low write pulse |
| oe_hv | input | 1 | High voltage present on the output-enable pin |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Read or identification data |
| dout_oe | output | 1 | Drive enable for the tri-state data buffer |
| busy | output | 1 | A program or erase pulse is in progress |
| pulse_error | output | 1 | The last pulse was too short or was aborted |

## Verification
The bench goes after pulses exactly one sample short of the minimum and exactly at the minimum. A design that miscounts by one cycle would either reject the exact-length pulse or commit the short one. It also programs a byte that already holds data and then tries to write FFh over it. A design that overwrote instead of ANDing would bring back bits that only erase may set. Identification is checked with the upper address bits set, including address bit 9, and with the two unused selector values; an incomplete decode would leak array data. A pulse broken off by dropping `ce_n` must leave the target byte erased, so a model that commits on abort is caught.

// File: rtl/prom_pkg.sv
package prom_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_DISABLE,
        M_READ,
        M_IDENT,
        M_INHIBIT,
        M_PROG,
        M_ERASE
    } mode_e;

    typedef enum logic {
        S_IDLE,
        S_PULSE
    } pstate_e;

    localparam logic [7:0] MFR_CODE = 8'h9D;
    localparam logic [7:0] DEV_CODE = 8'h9B;
    localparam logic [7:0] BLANK    = 8'hFF;

endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
    import prom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  we_n,
    input  logic  oe_hv,
    input  logic  a9_hv,
    output mode_e mode
);

    // Priority: select, then high voltage on OE, then the normal-level pins.
    always_comb begin
        if (ce_n)          mode = M_STANDBY;
        else if (oe_hv)    mode = a9_hv ? M_ERASE : M_PROG;
        else if (oe_n)     mode = M_DISABLE;
        else if (!we_n)    mode = M_INHIBIT;
        else if (a9_hv)    mode = M_IDENT;
        else               mode = M_READ;
    end

endmodule

// File: rtl/prom_pulse_ctl.sv
module prom_pulse_ctl
    import prom_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              busy,
    output logic              pulse_error,
    output logic              prog_en,
    output logic              erase_en,
    output logic [ADDR_W-1:0] waddr,
    output logic [7:0]        wdata
);

    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_CYC);
    localparam logic [CNT_W-1:0] NEED_PROG = CNT_W'(PROG_CYCLES);
    localparam logic [CNT_W-1:0] NEED_ERAS = CNT_W'(ERASE_CYCLES);

    typedef struct packed {
        pstate_e           st;
        logic              we_prev;
        logic              is_erase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wr_mode;
    logic same_kind;
    logic [CNT_W-1:0] need;

    always_comb begin
        ctl_d     = ctl_q;
        prog_en   = 1'b0;
        erase_en  = 1'b0;
        wr_mode   = (mode == M_PROG) || (mode == M_ERASE);
        same_kind = (mode == M_ERASE) == ctl_q.is_erase;
        need      = ctl_q.is_erase ? NEED_ERAS : NEED_PROG;
        ctl_d.we_prev = we_n;
        case (ctl_q.st)
            S_IDLE: begin
                if (ctl_q.we_prev && !we_n && wr_mode) begin
                    ctl_d.st       = S_PULSE;
                    ctl_d.is_erase = (mode == M_ERASE);
                    ctl_d.cnt      = CNT_W'(1);
                    ctl_d.addr     = addr;
                    ctl_d.data     = din;
                    ctl_d.err      = 1'b0;
                end
            end
            S_PULSE: begin
                if (!wr_mode || !same_kind) begin
                    ctl_d.st  = S_IDLE;
                    ctl_d.err = 1'b1;
                end else if (!we_n) begin
                    if (ctl_q.cnt != CNT_MAX) ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end else begin
                    ctl_d.st = S_IDLE;
                    if (ctl_q.cnt >= need) begin
                        prog_en  = !ctl_q.is_erase;
                        erase_en = ctl_q.is_erase;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, we_prev: 1'b1, is_erase: 1'b0, cnt: '0,
                       addr: '0, data: '0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.st == S_PULSE);
    assign pulse_error = ctl_q.err;
    assign waddr       = ctl_q.addr;
    assign wdata       = ctl_q.data;

    // R8: an error only appears at the end of a pulse
    assert_err_ends_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_error) |-> $past(busy));

    // R9: a write only commits out of an ongoing pulse, which then ends
    assert_commit_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |=> !busy);

endmodule

// File: rtl/prom_array.sv
module prom_array
    import prom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= BLANK;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= BLANK;
        end else if (prog_en) begin
            mem_q[waddr] <= mem_q[waddr] & wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R5: programming never raises a bit
    assert_no_bit_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem_q[$past(waddr)] & ~$past(mem_q[waddr])) == 8'h00));

    // R6: erase leaves both ends of the array blank
    assert_erase_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem_q[0] == BLANK && mem_q[DEPTH-1] == BLANK));

endmodule

// File: rtl/prom_model.sv
module prom_model
    import prom_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe,
    output logic              busy,
    output logic              pulse_error
);

    mode_e             mode;
    logic              prog_en, erase_en;
    logic [ADDR_W-1:0] waddr;
    logic [7:0]        wdata, rdata, id_code;

    prom_mode_dec u_dec (
        .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .mode (mode)
    );

    prom_pulse_ctl #(
        .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .we_n(we_n), .addr(addr), .din(din),
        .busy(busy), .pulse_error(pulse_error), .prog_en(prog_en), .erase_en(erase_en),
        .waddr(waddr), .wdata(wdata)
    );

    prom_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase_en(erase_en),
        .waddr(waddr), .wdata(wdata), .raddr(addr), .rdata(rdata)
    );

    always_comb begin
        case (addr[1:0])
            2'b00:   id_code = MFR_CODE;
            2'b01:   id_code = DEV_CODE;
            default: id_code = 8'h00;
        endcase
    end

    assign dout_oe = !busy && ((mode == M_READ) || (mode == M_IDENT));
    assign dout    = (mode == M_IDENT) ? id_code : rdata;

    // R2: deselected part never drives
    assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dout_oe);

    // R9: no drive while a pulse runs
    assert_busy_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dout_oe);

    // R7: manufacturer code on selector 00
    assert_ident_mfr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && !oe_hv && a9_hv && !busy && addr[1:0] == 2'b00)
        |-> (dout_oe && dout == 8'h9D));

endmodule

// File: tb/prom_model_bench.sv
module prom_model_bench;

    localparam int AW = 10;
    localparam int PC = 20;
    localparam int EC = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_oe, busy, pulse_error;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prom_model #(.ADDR_W(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_prom_model (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .busy(busy), .pulse_error(pulse_error)
    );

    // {req[3:0], ce_n, oe_n, we_n, oe_hv, a9_hv, addr[9:0], exp_oe, exp_dout[7:0]}
    localparam int NV = 11;
    localparam logic [27:0] VECS [NV] = '{
        {4'd1,  5'b00100, 10'd5,    1'b1, 8'hA5},
        {4'd1,  5'b00100, 10'd6,    1'b1, 8'hFF},
        {4'd1,  5'b00100, 10'd1023, 1'b1, 8'hFF},
        {4'd2,  5'b10100, 10'd5,    1'b0, 8'h00},
        {4'd2,  5'b10011, 10'd5,    1'b0, 8'h00},
        {4'd3,  5'b01100, 10'd5,    1'b0, 8'h00},
        {4'd7,  5'b00101, 10'd1020, 1'b1, 8'h9D},
        {4'd7,  5'b00101, 10'd1,    1'b1, 8'h9B},
        {4'd7,  5'b00101, 10'd2,    1'b1, 8'h00},
        {4'd7,  5'b00101, 10'd1023, 1'b1, 8'h00},
        {4'd3,  5'b00000, 10'd5,    1'b0, 8'h00}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pins(input logic c, input logic o, input logic w, input logic oh, input logic ah,
                        input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; oe_hv = oh; a9_hv = ah; addr = a; din = d;
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00);
        #1;
        check(req, "read", {dout_oe, dout}, {1'b1, exp});
    endtask

    // we_n held low for n sampling edges; results are visible on return
    task automatic pulse(input int n, input bit chk_busy);
        @(negedge clk);
        we_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0 && chk_busy) begin
                check("R9", "busy in pulse", busy, 1);
                check("R9", "hiz in pulse", dout_oe, 0);
            end
        end
        we_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d, input int n);
        pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a, d);
        pulse(n, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R10 reset state
        check("R10", "busy", busy, 0);
        check("R10", "pulse_error", pulse_error, 0);
        read_chk("R10", 10'd0, 8'hFF);
        read_chk("R10", 10'd1023, 8'hFF);

        // R4 program with a busy/hiz check during the pulse (R9)
        pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd5, 8'hA5);
        pulse(PC, 1'b1);
        check("R4", "no error", pulse_error, 0);
        check("R4", "idle", busy, 0);
        read_chk("R4", 10'd5, 8'hA5);

        // R1 R2 R3 R7 vector walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {ce_n, oe_n, we_n, oe_hv, a9_hv} = VECS[v][23:19];
            addr = VECS[v][18:9];
            #1;
            if (VECS[v][8])
                check($sformatf("R%0d", VECS[v][27:24]), $sformatf("vec %0d", v),
                      {dout_oe, dout}, {1'b1, VECS[v][7:0]});
            else
                check($sformatf("R%0d", VECS[v][27:24]), $sformatf("vec %0d", v),
                      dout_oe, 0);
        end
        @(negedge clk);
        we_n = 1'b1;

        // R5 AND semantics, FFh leaves data
        program_byte(10'd5, 8'h3C, PC);
        read_chk("R5", 10'd5, 8'h24);
        program_byte(10'd5, 8'hFF, PC + 3);
        read_chk("R5", 10'd5, 8'h24);

        // R8 short program pulse
        program_byte(10'd7, 8'h00, PC - 1);
        check("R8", "short prog error", pulse_error, 1);
        read_chk("R8", 10'd7, 8'hFF);
        check("R8", "error held", pulse_error, 1);

        // R8 short erase pulse
        pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd0, 8'h00);
        pulse(EC - 1, 1'b0);
        check("R8", "short erase error", pulse_error, 1);
        read_chk("R8", 10'd5, 8'h24);

        // R11 abort by deselect
        pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd8, 8'h00);
        @(negedge clk);
        we_n = 1'b0;
        repeat (PC + 2) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        #1;
        check("R11", "abort error", pulse_error, 1);
        check("R11", "abort idle", busy, 0);
        we_n = 1'b1;
        read_chk("R11", 10'd8, 8'hFF);

        // R6 erase at exact minimum, with noise on address and data
        program_byte(10'd1023, 8'h12, PC);
        read_chk("R4", 10'd1023, 8'h12);
        pins(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h155, 8'h5A);
        pulse(EC, 1'b1);
        check("R6", "erase no error", pulse_error, 0);
        read_chk("R6", 10'd5, 8'hFF);
        read_chk("R6", 10'd1023, 8'hFF);
        read_chk("R6", 10'h155, 8'hFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule